// File: doc/BRIEF.md
# Broadcast Configuration Writer for a Converter Daisy Chain

This block is a serial write master that programs every converter in a daisy chain with one frame. The host presents a 16-bit register address and a 16-bit value and pulses `start`. The block drives an active-low frame strobe, which all devices share, and a serial clock. It shifts the 32-bit word into the serial input at the far end of the chain. A single frame therefore configures all devices together, and they stay in step. One example is the power-mode register at address 0x0001, which must hold the same value in every device.

The host raises `chain_ready` once the converters have finished their reset and sync sequence. The block accepts no write before then. While a frame and the idle gap after it are in progress, `busy` is high and further start requests are dropped. `done` marks the end of each frame. All timing derives from the system clock through the parameter `HALF`, the number of system clocks in each half of a serial clock period.

Top module: `chain_cfg_writer`

## Requirements
- R1: A frame carries the 32-bit word {addr, data}: the address is in bits 31..16 and the value in bits 15..0. Bit 31 is shifted first and bit 0 last.
- R2: `frm_n` goes low in the cycle after a start is accepted and stays low for exactly 64*HALF clock cycles. The frame contains exactly 32 rising edges of `sclk`.
- R3: `sclk` rests high. Each frame begins with a low half-period, and every half-period lasts HALF clock cycles, so the first rising edge comes HALF cycles after `frm_n` falls.
- R4: Inside a frame, `sdo` changes only in the cycle where `sclk` falls. Each bit is therefore stable across the rising edge that samples it.
- R5: A start request while `chain_ready` is low is ignored: no frame begins and `busy` stays low.
- R6: `busy` stays high for 68*HALF cycles per write, which covers the frame and a gap of two serial clock periods with `frm_n` high. A start request during that time is ignored. With start held high, consecutive frames are 4*HALF+1 cycles apart.
- R7: `done` is high for exactly one cycle per frame, in the cycle where `frm_n` returns high.
- R8: After reset: `frm_n`=1, `sclk`=1, `sdo`=0, `busy`=0 and `done`=0.
- R9: The word is captured when the start is accepted. Changes on `addr` or `data` during a frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_ready | input | 1 | Converters have finished reset and sync; writes are allowed |
| start | input | 1 | Request a broadcast write |
| addr | input | 16 | Register address |
| data | input | 16 | Register value |
| frm_n | output | 1 | Shared active-low frame strobe |
| sclk | output | 1 | Serial clock, high when idle |
| sdo | output | 1 | Serial data into the chain's last device |
| busy | output | 1 | Frame or post-frame gap in progress |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
An accepted start on clock edge 0 pulls `frm_n` low after that edge. The first `sclk` rise follows after edge HALF, and bit k is presented from edge 2k*HALF. `frm_n` and `done` rise after edge 64*HALF, and `busy` falls after edge 68*HALF. A monitor samples every output on the falling clock edge, half a cycle away from any register update. It counts run lengths and captures `sdo` at each observed `sclk` rise, then compares the counts with these cycle numbers. Each scenario waits for `busy` to fall, plus spare cycles, before it reads the monitor's totals. A dropped start therefore shows up as a missing or extra frame.

// File: rtl/chain_cfg_writer.sv
module chain_cfg_writer #(
  parameter int HALF      = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int GAP_SCLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_ready,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              frm_n,
  output logic              sclk,
  output logic              sdo,
  output logic              busy,
  output logic              done
);
  localparam int WORD_W  = ADDR_W + DATA_W;
  localparam int GAP_CYC = 2 * GAP_SCLKS * HALF;
  localparam int CNT_W   = $clog2(GAP_CYC + 1);
  localparam int IDX_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic [WORD_W-1:0]  shreg;

  wire accept   = (state == S_IDLE) && start && chain_ready;
  wire half_end = (cnt == CNT_W'(HALF - 1));
  wire gap_end  = (cnt == CNT_W'(GAP_CYC - 1));
  wire last_bit = (bit_idx == IDX_W'(WORD_W - 1));

  assign busy = (state != S_IDLE);
  assign sdo  = !frm_n && shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      frm_n   <= 1'b1;
      sclk    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            shreg   <= {addr, data};
            frm_n   <= 1'b0;
            sclk    <= 1'b0;
            cnt     <= '0;
            bit_idx <= '0;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!half_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else if (last_bit) begin
              frm_n <= 1'b1;
              done  <= 1'b1;
              shreg <= '0;
              state <= S_GAP;
            end else begin
              sclk    <= 1'b0;
              shreg   <= {shreg[WORD_W-2:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gap_end) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_FRAME_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_n |-> busy); // R2
  AST_SCLK_RESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |-> sclk); // R3
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_n && !$past(frm_n) && !$stable(sdo)) |-> $fell(sclk)); // R4
  AST_NOT_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chain_ready) |=> !busy); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(frm_n)); // R7
endmodule

// File: tb/chain_cfg_writer_bench.sv
module chain_cfg_writer_bench;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0, chain_ready = 1'b0, start = 1'b0;
  logic [15:0] addr = '0, data = '0;
  logic frm_n, sclk, sdo, busy, done;

  int checks = 0, errors = 0;

  chain_cfg_writer #(.HALF(H)) u_chain_cfg_writer (
    .clk(clk), .rst_n(rst_n), .chain_ready(chain_ready), .start(start),
    .addr(addr), .data(data), .frm_n(frm_n), .sclk(sclk), .sdo(sdo),
    .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  logic [31:0] word_acc = '0, last_word = '0;
  int low_cnt = 0, rise_cnt = 0, last_low = 0, last_rises = 0;
  int first_low = 0, first_run = 0, seen_rise = 0;
  int frames = 0, done_cnt = 0, done_ok = 0, bad_sdo = 0;
  int hi_cnt = 0, last_gap = 0, busy_run = 0, last_busy = 0;
  logic p_frm = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!frm_n) begin
        low_cnt++;
        if (p_frm) begin first_run = 0; seen_rise = 0; last_gap = hi_cnt; end
        if (sclk && !p_sclk) begin
          word_acc = {word_acc[30:0], sdo};
          rise_cnt++;
          if (!seen_rise) begin first_low = first_run; seen_rise = 1; end
        end
        if (!seen_rise && !sclk) first_run++;
        if (!p_frm && sdo != p_sdo && !(p_sclk && !sclk)) bad_sdo++;
        hi_cnt = 0;
      end else begin
        hi_cnt++;
        if (!p_frm) begin
          frames++; last_word = word_acc; last_low = low_cnt; last_rises = rise_cnt;
          low_cnt = 0; rise_cnt = 0;
          if (done) done_ok++;
        end
      end
      if (done) done_cnt++;
      if (busy) busy_run++;
      else if (p_busy) begin last_busy = busy_run; busy_run = 0; end
      p_frm = frm_n; p_sclk = sclk; p_sdo = sdo; p_busy = busy;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 frm_n", frm_n, 1); chk("R8 sclk", sclk, 1); chk("R8 sdo", sdo, 0);
    chk("R8 busy", busy, 0); chk("R8 done", done, 0);
  endtask

  task automatic t_frame(input logic [15:0] a, input logic [15:0] d);
    int f0 = frames, dc0 = done_cnt, ok0 = done_ok, b0 = bad_sdo;
    addr = a; data = d;
    pulse_start();
    wait_idle();
    chk("R1 word", last_word, {a, d});
    chk("R2 frames", frames - f0, 1);
    chk("R2 low cycles", last_low, 64 * H);
    chk("R2 sclk rises", last_rises, 32);
    chk("R3 first low half", first_low, H);
    chk("R4 sdo off-fall changes", bad_sdo - b0, 0);
    chk("R7 done count", done_cnt - dc0, 1);
    chk("R7 done with frm rise", done_ok - ok0, 1);
    chk("R6 busy length", last_busy, 68 * H);
  endtask

  task automatic t_not_ready();
    int f0 = frames;
    chain_ready = 1'b0; addr = 16'h1234; data = 16'h5678;
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R5 busy", busy, 0);
    chk("R5 frames", frames - f0, 0);
    chain_ready = 1'b1;
  endtask

  task automatic t_busy_ignore();
    int f0 = frames;
    addr = 16'hA5A5; data = 16'h0F0F;
    pulse_start();
    repeat (20 * H) @(negedge clk);
    addr = 16'h5A5A; data = 16'hF0F0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    addr = 16'hFFFF; data = 16'hFFFF;
    wait_idle();
    chk("R6 one frame", frames - f0, 1);
    chk("R9 word kept", last_word, 32'hA5A50F0F);
  endtask

  task automatic t_back_to_back();
    int f0 = frames;
    addr = 16'h00C3; data = 16'h8001;
    @(negedge clk); start = 1'b1;
    while (frames - f0 < 1) @(negedge clk);
    while (frm_n) @(negedge clk);
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R6 gap", last_gap, 4 * H + 1);
    chk("R6 frames", frames - f0, 2);
    chk("R1 word b2b", last_word, 32'h00C38001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_not_ready();
    t_frame(16'h0001, 16'h0002);
    t_frame(16'h8000, 16'h0001);
    t_frame(16'hFFFF, 16'h0000);
    t_frame(16'h3C96, 16'hE17B);
    t_busy_ignore();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule